// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock domains of a small microcontroller run. It has four power states: active, standby, watch and stop. The instruction decoder raises a standby request or a stop request. A timer-mode select bit then picks between the deep stop state and the lighter watch state. From the current state the block drives enables for the main oscillator, the sub-oscillator, the peripheral clocks and the CPU clocks.

The sleep states differ in what can end them. Standby ends on any unmasked interrupt source. Watch ends only on the three highest-priority sources. Stop ignores all interrupts and ends only when the external reset pin or the stop-clear pin has been held low for a stabilization interval. A retained-RAM flag records which of those two pins ended stop. After an interrupt wake, the block issues a restart strobe. It also says whether the interrupt will be taken, which depends on the global enable, and it reports the index of the waking source.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the state is active. In that state all four clock enables are 1, `ram_kept` is 0, and `wake_o`, `int_take` and `mcu_rst_o` are 0.
- R2: In active, `stop_req` with `tmode_sel`=0 enters stop at the next edge, and `stop_req` with `tmode_sel`=1 enters watch. `sby_req` alone enters standby. When both requests are present, `stop_req` wins.
- R3: The enables per state are as follows. Standby: osc=1, sub=1, per=1, cpu=0. Watch: sub=1, all others 0. Stop: osc, per and cpu are 0, and `sub_en` is the inverse of `sub_off` as sampled at stop entry.
- R4: A source i is pending when `irq_flag[i]`=1 and `irq_mask[i]`=0. In standby or watch, a pending source with index 0, 1 or 2 returns the state to active at the next edge, with `wake_o` high for exactly one cycle.
- R5: Sources 3 to 9 wake the block from standby only. In watch they are ignored, and all enables keep their watch values.
- R6: On an interrupt wake, `wake_src` gives the lowest index among the pending sources that are eligible in the current state. Index 0 has the highest priority.
- R7: `int_take` is 1 in the cycle of an interrupt wake exactly when `gie` is 1. At all other times it is 0.
- R8: Stop ignores interrupts. Holding `stop_clr_n` low for STAB_CYC consecutive edges returns the block to active at the last of those edges. At that point `ram_kept` becomes 1 and `wake_o` pulses, while `int_take` stays 0.
- R9: Holding `ext_rst_n` low for STAB_CYC consecutive edges forces active from any state. `mcu_rst_o` pulses for one cycle and `ram_kept` becomes 0.
- R10: A low pulse on `ext_rst_n` or `stop_clr_n` lasting fewer than STAB_CYC edges has no effect.
- R11: When both exit pins qualify at the same edge, the reset exit wins. `mcu_rst_o` is 1, `wake_o` is 0 and `ram_kept` is 0.
- R12: `stop_clr_n` has no effect outside stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sby_req | input | 1 | Standby request from the decoder |
| stop_req | input | 1 | Stop/watch request from the decoder |
| tmode_sel | input | 1 | 0: stop request enters stop, 1: enters watch |
| sub_off | input | 1 | 1 stops the sub-oscillator during stop |
| ext_rst_n | input | 1 | External reset pin, active low |
| stop_clr_n | input | 1 | Stop-clear pin, active low |
| irq_flag | input | 10 | Interrupt flags, index 0 highest priority |
| irq_mask | input | 10 | Interrupt masks, 1 masks |
| gie | input | 1 | Global interrupt enable |
| osc_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Sub-oscillator enable |
| per_en | output | 1 | Peripheral clock enable |
| cpu_en | output | 1 | CPU clock enable |
| ram_kept | output | 1 | 1 when stop was left by stop-clear |
| wake_o | output | 1 | One-cycle restart strobe to the CPU |
| int_take | output | 1 | Wake interrupt will be accepted |
| wake_src | output | 4 | Index of the waking source |
| mcu_rst_o | output | 1 | One-cycle whole-chip reset request |

## Verification
Two situations can fall in the same cycle. In the first, both exit pins reach their qualification count at the same edge. The bench provokes this by pulling both pins low together while in stop. It then judges that the reset exit alone is taken: `mcu_rst_o` is high, `wake_o` is low and the retained flag is cleared, even though the flag was set beforehand. In the second, several interrupt sources rise together in standby or watch. The bench sweeps every pair of sources and compares `wake_src` with the lowest eligible index, which it computes itself.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int NSRC       = 10;
    localparam int WATCH_SRCS = 3;
    localparam int SRC_W      = $clog2(NSRC);

    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'd0,
        PM_STANDBY = 2'd1,
        PM_WATCH   = 2'd2,
        PM_STOP    = 2'd3
    } pmode_e;

    typedef struct packed {
        logic osc;
        logic sub;
        logic per;
        logic cpu;
    } clk_en_t;

    // Clock enables as a function of the state and the latched sub-oscillator choice
    function automatic clk_en_t clk_en_for(pmode_e m, logic sub_keep);
        clk_en_t e;
        case (m)
            PM_ACTIVE:  e = '{osc: 1'b1, sub: 1'b1, per: 1'b1, cpu: 1'b1};
            PM_STANDBY: e = '{osc: 1'b1, sub: 1'b1, per: 1'b1, cpu: 1'b0};
            PM_WATCH:   e = '{osc: 1'b0, sub: 1'b1, per: 1'b0, cpu: 1'b0};
            default:    e = '{osc: 1'b0, sub: sub_keep, per: 1'b0, cpu: 1'b0};
        endcase
        return e;
    endfunction

    // Lowest set index wins
    function automatic logic [SRC_W-1:0] first_set(logic [NSRC-1:0] v);
        logic [SRC_W-1:0] idx;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) idx = SRC_W'(i);
        end
        return idx;
    endfunction

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
    } wake_req_t;

endpackage

// File: rtl/pwr_exit_filter.sv
module pwr_exit_filter #(
    parameter int STAB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic qual
);
    localparam int CNT_W = $clog2(STAB_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYC - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(STAB_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || pin_n) begin
            cnt_q <= '0;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires once, on the STAB_CYC-th consecutive low sample
    assign qual = !pin_n && (cnt_q == LAST);

endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
    import pwr_mode_pkg::*;
(
    input  pmode_e          mode,
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] mask,
    output wake_req_t       req
);
    logic [NSRC-1:0] allow;
    logic [NSRC-1:0] pend;

    for (genvar i = 0; i < NSRC; i++) begin : g_allow
        if (i < WATCH_SRCS) begin : g_any
            assign allow[i] = (mode == PM_STANDBY) || (mode == PM_WATCH);
        end else begin : g_sby
            assign allow[i] = (mode == PM_STANDBY);
        end
    end

    assign pend    = flag & ~mask & allow;
    assign req.hit = |pend;
    assign req.src = first_set(pend);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sby_req,
    input  logic             stop_req,
    input  logic             tmode_sel,
    input  logic             sub_off,
    input  logic             rst_qual,
    input  logic             clr_qual,
    input  wake_req_t        wreq,
    input  logic             gie,
    output pmode_e           mode,
    output logic             sub_keep,
    output logic             ram_kept,
    output logic             wake_o,
    output logic             int_take,
    output logic [SRC_W-1:0] wake_src,
    output logic             mcu_rst_o
);
    pmode_e           mode_q, mode_d;
    logic             keep_q, keep_d;
    logic             ram_q, ram_d;
    logic             wake_q, wake_d;
    logic             take_q, take_d;
    logic [SRC_W-1:0] src_q, src_d;
    logic             mrst_q, mrst_d;

    always_comb begin
        mode_d = mode_q;
        keep_d = keep_q;
        ram_d  = ram_q;
        wake_d = 1'b0;
        take_d = 1'b0;
        src_d  = src_q;
        mrst_d = 1'b0;
        if (rst_qual) begin
            mode_d = PM_ACTIVE;
            ram_d  = 1'b0;
            mrst_d = 1'b1;
        end else begin
            case (mode_q)
                PM_ACTIVE: begin
                    if (stop_req) begin
                        mode_d = tmode_sel ? PM_WATCH : PM_STOP;
                        keep_d = !sub_off;
                    end else if (sby_req) begin
                        mode_d = PM_STANDBY;
                    end
                end
                PM_STOP: begin
                    if (clr_qual) begin
                        mode_d = PM_ACTIVE;
                        ram_d  = 1'b1;
                        wake_d = 1'b1;
                    end
                end
                default: begin
                    if (wreq.hit) begin
                        mode_d = PM_ACTIVE;
                        wake_d = 1'b1;
                        take_d = gie;
                        src_d  = wreq.src;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_ACTIVE;
            keep_q <= 1'b1;
            ram_q  <= 1'b0;
            wake_q <= 1'b0;
            take_q <= 1'b0;
            src_q  <= '0;
            mrst_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            keep_q <= keep_d;
            ram_q  <= ram_d;
            wake_q <= wake_d;
            take_q <= take_d;
            src_q  <= src_d;
            mrst_q <= mrst_d;
        end
    end

    assign mode      = mode_q;
    assign sub_keep  = keep_q;
    assign ram_kept  = ram_q;
    assign wake_o    = wake_q;
    assign int_take  = take_q;
    assign wake_src  = src_q;
    assign mcu_rst_o = mrst_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sby_req,
    input  logic             stop_req,
    input  logic             tmode_sel,
    input  logic             sub_off,
    input  logic             ext_rst_n,
    input  logic             stop_clr_n,
    input  logic [NSRC-1:0]  irq_flag,
    input  logic [NSRC-1:0]  irq_mask,
    input  logic             gie,
    output logic             osc_en,
    output logic             sub_en,
    output logic             per_en,
    output logic             cpu_en,
    output logic             ram_kept,
    output logic             wake_o,
    output logic             int_take,
    output logic [SRC_W-1:0] wake_src,
    output logic             mcu_rst_o
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins_n;
    logic [NPIN-1:0] quals;
    pmode_e          mode;
    logic            sub_keep;
    wake_req_t       wreq;
    clk_en_t         en;

    // index 0: reset pin, index 1: stop-clear pin
    assign pins_n = {stop_clr_n, ext_rst_n};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pwr_exit_filter #(.STAB_CYC(STAB_CYC)) u_flt (
            .clk   (clk),
            .rst   (rst),
            .pin_n (pins_n[p]),
            .qual  (quals[p])
        );
    end

    pwr_wake_arb u_arb (
        .mode (mode),
        .flag (irq_flag),
        .mask (irq_mask),
        .req  (wreq)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sby_req   (sby_req),
        .stop_req  (stop_req),
        .tmode_sel (tmode_sel),
        .sub_off   (sub_off),
        .rst_qual  (quals[0]),
        .clr_qual  (quals[1]),
        .wreq      (wreq),
        .gie       (gie),
        .mode      (mode),
        .sub_keep  (sub_keep),
        .ram_kept  (ram_kept),
        .wake_o    (wake_o),
        .int_take  (int_take),
        .wake_src  (wake_src),
        .mcu_rst_o (mcu_rst_o)
    );

    assign en     = clk_en_for(mode, sub_keep);
    assign osc_en = en.osc;
    assign sub_en = en.sub;
    assign per_en = en.per;
    assign cpu_en = en.cpu;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic osc_en,
    input logic sub_en,
    input logic per_en,
    input logic cpu_en,
    input logic ram_kept,
    input logic wake_o,
    input logic int_take,
    input logic mcu_rst_o
);
    // R1
    reset_active_chk: assert property (@(posedge clk)
        rst |=> (osc_en && sub_en && per_en && cpu_en && !ram_kept && !wake_o && !mcu_rst_o));

    // R3
    cpu_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_en && !osc_en) |-> !per_en);

    // R4
    wake_active_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> cpu_en);

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);

    // R7
    take_needs_wake_chk: assert property (@(posedge clk) disable iff (rst)
        int_take |-> wake_o);

    // R9
    reset_exit_ram_chk: assert property (@(posedge clk) disable iff (rst)
        mcu_rst_o |-> (!ram_kept && cpu_en));

    // R11
    exit_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wake_o, mcu_rst_o}));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_en    (osc_en),
    .sub_en    (sub_en),
    .per_en    (per_en),
    .cpu_en    (cpu_en),
    .ram_kept  (ram_kept),
    .wake_o    (wake_o),
    .int_take  (int_take),
    .mcu_rst_o (mcu_rst_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int STAB = 4;
    localparam int NS   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sby_req = 0, stop_req = 0, tmode_sel = 0, sub_off = 0;
    logic ext_rst_n = 1, stop_clr_n = 1, gie = 0;
    logic [NS-1:0] irq_flag = '0, irq_mask = '0;
    logic osc_en, sub_en, per_en, cpu_en, ram_kept, wake_o, int_take, mcu_rst_o;
    logic [3:0] wake_src;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.STAB_CYC(STAB)) dut (
        .clk(clk), .rst(rst), .sby_req(sby_req), .stop_req(stop_req),
        .tmode_sel(tmode_sel), .sub_off(sub_off), .ext_rst_n(ext_rst_n),
        .stop_clr_n(stop_clr_n), .irq_flag(irq_flag), .irq_mask(irq_mask),
        .gie(gie), .osc_en(osc_en), .sub_en(sub_en), .per_en(per_en),
        .cpu_en(cpu_en), .ram_kept(ram_kept), .wake_o(wake_o),
        .int_take(int_take), .wake_src(wake_src), .mcu_rst_o(mcu_rst_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int en4();
        return {osc_en, sub_en, per_en, cpu_en};
    endfunction

    task automatic do_reset();
        irq_flag = '0; irq_mask = '0; gie = 0;
        sby_req = 0; stop_req = 0; ext_rst_n = 1; stop_clr_n = 1;
        rst = 1;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic go_standby();
        sby_req = 1; step(); sby_req = 0;
    endtask

    task automatic go_stop(input logic so);
        stop_req = 1; tmode_sel = 0; sub_off = so; step(); stop_req = 0;
    endtask

    task automatic go_watch();
        stop_req = 1; tmode_sel = 1; step(); stop_req = 0;
    endtask

    task automatic clr_exit();
        stop_clr_n = 0;
        for (int k = 0; k < STAB; k++) step();
        stop_clr_n = 1;
        step();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        step(); step();
        rst = 0;
        step();
        chk("R1 enables", en4(), 4'b1111);
        chk("R1 ram_kept", ram_kept, 0);
        chk("R1 strobes", {wake_o, int_take, mcu_rst_o}, 0);

        // R2/R3 entries and enable patterns
        go_standby();
        chk("R2 R3 standby enables", en4(), 4'b1110);
        do_reset();
        go_watch();
        chk("R2 R3 watch enables", en4(), 4'b0100);
        do_reset();
        for (int so = 0; so < 2; so++) begin
            go_stop(so[0]);
            sub_off = ~so[0];
            step();
            chk("R3 stop enables", en4(), so ? 4'b0000 : 4'b0100);
            do_reset();
        end
        stop_req = 1; sby_req = 1; tmode_sel = 1; step(); stop_req = 0; sby_req = 0;
        chk("R2 stop request wins", en4(), 4'b0100);
        do_reset();

        // R4 R5 R7 single-source sweep
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < NS; i++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int g = 0; g < 2; g++) begin
                        bit ex;
                        if (w == 0) go_standby(); else go_watch();
                        ex = (m == 0) && (w == 0 || i < 3);
                        irq_flag[i] = 1; irq_mask[i] = m[0]; gie = g[0];
                        step();
                        chk(w ? "R5 watch wake" : "R4 standby wake", cpu_en, ex);
                        chk("R4 wake strobe", wake_o, ex);
                        chk("R7 int_take", int_take, ex && g);
                        if (ex) chk("R6 src", wake_src, i);
                        if (!ex && w == 1) chk("R5 watch kept", en4(), 4'b0100);
                        irq_flag = '0; irq_mask = '0;
                        step();
                        chk("R4 strobe one cycle", wake_o, 0);
                        do_reset();
                    end
                end
            end
        end

        // R6 pair priority sweep
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < NS; i++) begin
                for (int j = i + 1; j < NS; j++) begin
                    if (w == 0) go_standby(); else go_watch();
                    irq_flag[i] = 1; irq_flag[j] = 1;
                    step();
                    if (w == 0 || i < 3) begin
                        chk("R6 pair wake", wake_o, 1);
                        chk("R6 pair src", wake_src, i);
                    end else begin
                        chk("R5 pair ignored", cpu_en, 0);
                    end
                    do_reset();
                end
            end
        end

        // R8 stop ignores irqs, R10 short pulses
        for (int len = 1; len <= STAB + 1; len++) begin
            go_stop(0);
            irq_flag = '1; gie = 1;
            step();
            chk("R8 irq ignored in stop", cpu_en, 0);
            irq_flag = '0;
            stop_clr_n = 0;
            for (int k = 0; k < len; k++) begin
                step();
                if (k == STAB - 1) begin
                    chk("R8 clear wake", wake_o, 1);
                    chk("R8 no take", int_take, 0);
                end
            end
            chk(len >= STAB ? "R8 clear exit" : "R10 short clear", cpu_en, len >= STAB);
            chk("R8 ram_kept", ram_kept, len >= STAB);
            stop_clr_n = 1;
            step();
            do_reset();
        end

        // R9 reset exit from stop with R10 short pulses
        for (int len = 1; len <= STAB + 1; len++) begin
            go_stop(0);
            clr_exit();
            go_stop(0);
            ext_rst_n = 0;
            for (int k = 0; k < len; k++) begin
                step();
                if (k == STAB - 1) chk("R9 reset pulse", mcu_rst_o, 1);
            end
            chk(len >= STAB ? "R9 reset exit" : "R10 short reset", cpu_en, len >= STAB);
            chk("R9 ram cleared", ram_kept, len < STAB);
            ext_rst_n = 1;
            step();
            chk("R9 pulse single", mcu_rst_o, 0);
            do_reset();
        end

        // R9 reset exit from standby
        go_standby();
        ext_rst_n = 0;
        for (int k = 0; k < STAB; k++) step();
        chk("R9 standby reset", {cpu_en, mcu_rst_o}, 2'b11);
        ext_rst_n = 1;
        do_reset();

        // R11 both exits qualify together
        go_stop(0);
        clr_exit();
        go_stop(0);
        ext_rst_n = 0; stop_clr_n = 0;
        for (int k = 0; k < STAB; k++) step();
        chk("R11 reset wins", mcu_rst_o, 1);
        chk("R11 no wake", wake_o, 0);
        chk("R11 ram cleared", ram_kept, 0);
        ext_rst_n = 1; stop_clr_n = 1;
        do_reset();

        // R12 stop-clear ignored in active and standby
        go_stop(0);
        clr_exit();
        stop_clr_n = 0;
        for (int k = 0; k < STAB + 2; k++) begin
            step();
            chk("R12 no wake in active", wake_o, 0);
        end
        stop_clr_n = 1;
        step();
        chk("R12 ram unchanged", ram_kept, 1);
        go_standby();
        stop_clr_n = 0;
        for (int k = 0; k < STAB + 2; k++) step();
        chk("R12 standby held", en4(), 4'b1110);
        stop_clr_n = 1;
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule